// File: doc/BRIEF.md
# Interrupt Event and Mask Controller

This block collects interrupt events for a network controller. Internal sources raise one-cycle pulses on a 32-bit set vector. Each pulse sets the matching bit of an event register, and the bit stays set until software clears it. Software reaches the block over a simple register bus. It clears event bits by writing ones to the event register, and it reads or writes a 32-bit mask register. The active set is the event register ANDed with the mask.

The block drives thirteen separate level outputs rather than a single ORed request. Each output follows one bit of the active set, taken from the upper thirteen bit positions. Each output is registered. It changes only when its active bit differs from the value it last recorded, and that comparison is made once per clock.

Top module: `irq_evt_ctrl`

## Requirements
- R1: While reset is asserted, and just after it is released, the event register, the mask register and all thirteen lines read zero.
- R2: A one on evt_set bit b sets event bit b at the next clock edge, and a read at offset 0x004 then returns it. The bit stays set until it is cleared.
- R3: A bus write to offset 0x004 clears every event bit written as one and leaves every bit written as zero unchanged.
- R4: If a set pulse and a write-one clear hit the same event bit in the same cycle, the bit ends up set.
- R5: A bus write to offset 0x008 stores all 32 data bits in the mask register, and a read at offset 0x008 returns them.
- R6: Output line i carries event bit (31 - i) ANDed with mask bit (31 - i), one clock edge after those register bits take their values. Line 0 follows bit 31, and line 12 follows bit 19.
- R7: Event bits 0 to 18 latch and read back like the other bits, but they never affect any output line.
- R8: Writes to any offset other than 0x004 and 0x008 change no state, and reads of those offsets return zero.
- R9: A line holds its level in every cycle in which its bit of the active set matches the level it last recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_set | input | 32 | One-cycle set pulses from event sources, one bit per event |
| bus_addr | input | 10 | Register byte offset, used for reads and writes |
| bus_wr | input | 1 | Write strobe, active for one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr and the registers |
| irq_line | output | 13 | Per-event interrupt levels; line i follows active bit 31 - i |

## Verification
A set pulse or a bus write applied before edge k appears in the registers, and so on bus_rdata, right after edge k. The interrupt lines reflect that register state one edge later, at k+1. The bench keeps a model in which each edge first computes the next line levels from the old registers and then updates the registers, and this matches the two-stage timing. The bench drives inputs and compares outputs only on the falling edge. Read data is compared a short delay after the address is driven, and always before the next rising edge.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned N_LINES  = 13;
  localparam logic [ADDR_W-1:0] OFS_EVENT = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 10'h008;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_MASK  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_pulse,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] clr_eff;

  always_comb clr_eff = clr_en ? clr_bits : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_eff) | set_pulse;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int unsigned W       = 32,
  parameter int unsigned N_LINES = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       active,
  output logic [N_LINES-1:0] line_q
);
  localparam int unsigned TOP_BIT = W - 1;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic src;
    assign src = active[TOP_BIT - i];
    // level moves only when the recorded value differs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              line_q[i] <= 1'b0;
      else if (src != line_q[i]) line_q[i] <= src;
    end
  end
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_set,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_LINES-1:0] irq_line
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] evt_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] active;

  always_comb begin
    if (bus_addr == OFS_EVENT)     sel = SEL_EVENT;
    else if (bus_addr == OFS_MASK) sel = SEL_MASK;
    else                           sel = SEL_NONE;
  end

  irq_evt_latch #(.W(DATA_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (evt_set),
    .clr_en    (bus_wr && sel == SEL_EVENT),
    .clr_bits  (bus_wdata),
    .evt_q     (evt_q)
  );

  irq_mask_reg #(.W(DATA_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && sel == SEL_MASK),
    .wr_data (bus_wdata),
    .mask_q  (mask_q)
  );

  always_comb active = evt_q & mask_q;

  irq_line_drv #(.W(DATA_W), .N_LINES(N_LINES)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .line_q (irq_line)
  );

  always_comb begin
    unique case (sel)
      SEL_EVENT: bus_rdata = evt_q;
      SEL_MASK:  bus_rdata = mask_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_evt_chk.sv
module irq_evt_chk
  import irq_evt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [DATA_W-1:0]  evt_set,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [N_LINES-1:0] irq_line,
  input logic [DATA_W-1:0]  evt_q,
  input logic [DATA_W-1:0]  mask_q
);
  function automatic logic [N_LINES-1:0] pick(input logic [DATA_W-1:0] v);
    logic [N_LINES-1:0] r;
    for (int i = 0; i < N_LINES; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  // R2 / R4: every pulsed bit is set after the edge, clear or not
  a_r2_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  // R3: bits written as one without a set pulse are cleared
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EVENT)
      |=> ((evt_q & $past(bus_wdata & ~evt_set)) == '0));

  // R5: mask write is stored
  a_r5_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MASK) |=> (mask_q == $past(bus_wdata)));

  // R6: lines follow the masked events one edge later
  a_r6_line_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line == pick($past(evt_q & mask_q))));

  // R8: unmapped offsets read zero
  a_r8_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFS_EVENT && bus_addr != OFS_MASK) |-> (bus_rdata == '0));

  // R9: no line moves while its active bit matches it
  a_r9_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pick(evt_q & mask_q) == irq_line) |=> $stable(irq_line));
endmodule

bind irq_evt_ctrl irq_evt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_set   (evt_set),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_line  (irq_line),
  .evt_q     (evt_q),
  .mask_q    (mask_q)
);

// File: tb/tb_irq_evt_ctrl.sv
module tb_irq_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_set = '0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [12:0] irq_line;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_evt = '0, m_mask = '0;
  logic [12:0] m_line = '0;

  irq_evt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_line(irq_line)
  );

  always #5 clk = ~clk;

  function automatic logic [12:0] pick(input logic [31:0] v);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs already driven; advance model across the rising edge
  task automatic step();
    @(posedge clk);
    m_line = pick(m_evt & m_mask);
    if (bus_wr && bus_addr == 10'h004) m_evt = m_evt & ~bus_wdata;
    if (bus_wr && bus_addr == 10'h008) m_mask = bus_wdata;
    m_evt = m_evt | evt_set;
    @(negedge clk);
    evt_set = '0; bus_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    read_chk("R1 event", 10'h004, 32'h0);
    read_chk("R1 mask", 10'h008, 32'h0);
    check("R1 lines", {19'h0, irq_line}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read_chk("R1 event after release", 10'h004, 32'h0);

    // R5: mask all ones
    bus_addr = 10'h008; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; step();
    read_chk("R5 mask readback", 10'h008, 32'hFFFF_FFFF);

    // R2 + R6: bit 31 -> line 0 timing
    evt_set = 32'h8000_0000; step();
    read_chk("R2 event set", 10'h004, 32'h8000_0000);
    check("R6 line not yet", {19'h0, irq_line}, 32'h0);
    step();
    check("R6 line0 high", {19'h0, irq_line}, 32'h1);

    // R4: set and clear same bit 19 same cycle
    evt_set = 32'h0008_0000; bus_addr = 10'h004;
    bus_wdata = 32'h0008_0000; bus_wr = 1'b1; step();
    read_chk("R4 set wins", 10'h004, 32'h8008_0000);
    step();
    check("R6 line12 high", {19'h0, irq_line}, 32'h1001);

    // R7: low bits latch but drive no line
    evt_set = 32'h0007_FFFF; step(); step();
    read_chk("R7 low bits latch", 10'h004, 32'h800F_FFFF);
    check("R7 no line from low bits", {19'h0, irq_line}, 32'h1001);

    // R3: W1C of bit 31 and low bits; bit 19 kept
    bus_addr = 10'h004; bus_wdata = 32'h8007_FFFF; bus_wr = 1'b1; step();
    read_chk("R3 w1c", 10'h004, 32'h0008_0000);
    check("R9 line0 still high one edge", {19'h0, irq_line}, 32'h1001);
    step();
    check("R6 line0 low", {19'h0, irq_line}, 32'h1000);

    // R8: write elsewhere, read elsewhere
    bus_addr = 10'h00C; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; step();
    bus_addr = 10'h000; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; step();
    read_chk("R8 bad read", 10'h00C, 32'h0);
    read_chk("R8 event untouched", 10'h004, 32'h0008_0000);
    read_chk("R8 mask untouched", 10'h008, 32'hFFFF_FFFF);

    // R6 masking: clear mask bit 19
    bus_addr = 10'h008; bus_wdata = 32'hFFF7_FFFF; bus_wr = 1'b1; step(); step();
    check("R6 masked line12 low", {19'h0, irq_line}, 32'h0);
    read_chk("R6 event kept under mask", 10'h004, 32'h0008_0000);

    // random phase
    for (int n = 0; n < 2000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      evt_set = $urandom & $urandom & $urandom;
      if (op < 3) begin bus_addr = 10'h004; bus_wdata = $urandom; bus_wr = 1'b1; end
      else if (op < 4) begin bus_addr = 10'h008; bus_wdata = $urandom | $urandom; bus_wr = 1'b1; end
      else if (op < 5) begin bus_addr = 10'($urandom_range(0, 1023)); bus_wdata = $urandom; bus_wr = 1'b1; end
      step();
      check("R6 random lines", {19'h0, irq_line}, {19'h0, m_line});
      case (n % 3)
        0: read_chk("R2/R3 random event", 10'h004, m_evt);
        1: read_chk("R5 random mask", 10'h008, m_mask);
        default: read_chk("R8 random read", 10'h3F0, 32'h0);
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule